// File: doc/BRIEF.md
# Stochastic Stream Probability Tracker

This block recovers the probability carried by a binary stochastic stream, one bit per clock. It keeps a fixed-point estimate of that probability. Each accepted stream bit moves the estimate part of the way toward the bit: the estimate becomes (1 - beta) * old + beta * bit. Because beta is a power of two, the step needs only a subtraction, an arithmetic shift and an addition.

The factor beta is not constant during a decoding attempt. A decoding-cycle counter counts the accepted bits since the last load. The factor starts at 1/4, where the estimate reacts quickly. It drops to 1/8 and then to 1/16 at fixed cycle boundaries, so the estimate settles as the decode goes on. A load strobe writes a starting probability (the channel prior) into the estimate and clears the cycle counter. The same strobe restarts a fresh attempt on the same frame.

Top module: `stream_prob_tracker`

## Requirements
- R1: After reset, prob_o is 0x8000 (one half, where prob_o/65536 is the probability) and the cycle counter is zero, so the first accepted bit uses beta = 1/4.
- R2: A clock with load_i high sets prob_o to prior_i on the next cycle and clears the cycle counter, so the next accepted bit is decoding cycle 0.
- R3: When load_i and valid_i are both high, the load wins and the stream bit is discarded.
- R4: With load_i and valid_i both low, prob_o keeps its value whatever bit_i does.
- R5: An accepted bit b moves the estimate to p + ((b ? 65536 : 0) - p) >> k. Here the shift is arithmetic (it rounds toward minus infinity) and beta = 2^-k.
- R6: Decoding cycles 0 through 33 use k = 2 (beta = 1/4).
- R7: Decoding cycles 34 through 110 use k = 3 (beta = 1/8).
- R8: Decoding cycles from 111 onward use k = 4 (beta = 1/16).
- R9: The estimate stays within 0 to 65535 and never wraps, under long runs of ones or of zeros.
- R10: The 8-bit cycle counter stops at 255 instead of rolling over, so beta stays at 1/16 for every cycle past 255.
- R11: A load in the middle of a decode returns the schedule to beta = 1/4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Preset estimate to prior_i and restart the cycle count |
| prior_i | input | 16 | Starting probability, unsigned fraction of 65536 |
| valid_i | input | 1 | bit_i carries a stream bit this clock |
| bit_i | input | 1 | Current stochastic stream bit |
| prob_o | output | 16 | Current probability estimate, unsigned fraction of 65536 |

## Verification
The bench aims at the schedule boundaries at cycles 33/34 and 110/111. A design that switched one cycle early or late would produce a different step on exactly those bits. It also drives long runs of ones and zeros toward both ends of the range. A tracker that rounded the wrong way, or lacked clamping, would stop short of zero or wrap past full scale. It then runs beyond 256 cycles, where a counter that wrapped would fall back to the fast factor. It also checks a load in the same clock as a valid bit, where letting the bit through would corrupt the new prior.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic [1:0] {
    STG_FAST = 2'd0,
    STG_MID  = 2'd1,
    STG_SLOW = 2'd2
  } relax_stage_e;

  function automatic relax_stage_e stage_of(input int unsigned cyc,
                                            input int unsigned fast_last,
                                            input int unsigned mid_last);
    if (cyc <= fast_last)     return STG_FAST;
    else if (cyc <= mid_last) return STG_MID;
    else                      return STG_SLOW;
  endfunction

endpackage

// File: rtl/srt_sched.sv
module srt_sched
  import srt_pkg::*;
#(
  parameter int CW        = 8,
  parameter int FAST_LAST = 33,
  parameter int MID_LAST  = 110,
  parameter int SH_FAST   = 2,
  parameter int SH_MID    = 3,
  parameter int SH_SLOW   = 4,
  parameter int KW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [CW-1:0] cnt_o,
  output logic [KW-1:0] shift_o
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  relax_stage_e  stage;

  always_comb begin
    cnt_en = clr_i | (adv_i & (cnt_q != CNT_MAX));
    cnt_d  = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    stage = stage_of(int'(cnt_q), FAST_LAST, MID_LAST);
    unique case (stage)
      STG_FAST: shift_o = KW'(SH_FAST);
      STG_MID:  shift_o = KW'(SH_MID);
      default:  shift_o = KW'(SH_SLOW);
    endcase
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/srt_step.sv
module srt_step #(
  parameter int PW = 16,
  parameter int KW = 3
) (
  input  logic [PW-1:0] p_i,
  input  logic          bit_i,
  input  logic [KW-1:0] shift_i,
  output logic [PW-1:0] p_o
);

  localparam int XW = PW + 2;
  localparam logic signed [XW-1:0] ONE_X = {2'b01, {PW{1'b0}}};
  localparam logic signed [XW-1:0] TOP_X = {2'b00, {PW{1'b1}}};

  logic signed [XW-1:0] p_x, target, diff, delta, sum;

  always_comb begin
    p_x    = $signed({2'b00, p_i});
    target = bit_i ? ONE_X : '0;
    diff   = target - p_x;
    delta  = diff >>> shift_i;
    sum    = p_x + delta;
    if (sum < 0)          p_o = '0;
    else if (sum > TOP_X) p_o = TOP_X[PW-1:0];
    else                  p_o = sum[PW-1:0];
  end

endmodule

// File: rtl/stream_prob_tracker.sv
module stream_prob_tracker #(
  parameter int PW         = 16,
  parameter int CW         = 8,
  parameter int FAST_LAST  = 33,
  parameter int MID_LAST   = 110,
  parameter int SH_FAST    = 2,
  parameter int SH_MID     = 3,
  parameter int SH_SLOW    = 4,
  parameter logic [PW-1:0] RESET_PROB = {1'b1, {(PW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] prior_i,
  input  logic          valid_i,
  input  logic          bit_i,
  output logic [PW-1:0] prob_o
);

  localparam int KW = 3;

  logic [CW-1:0] cyc_cnt;
  logic [KW-1:0] shift_k;
  logic [PW-1:0] prob_q, prob_d, step_p;
  logic          accept, prob_en;

  assign accept  = valid_i & ~load_i;
  assign prob_en = load_i | valid_i;

  srt_sched #(
    .CW(CW), .FAST_LAST(FAST_LAST), .MID_LAST(MID_LAST),
    .SH_FAST(SH_FAST), .SH_MID(SH_MID), .SH_SLOW(SH_SLOW), .KW(KW)
  ) u_sched (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (load_i),
    .adv_i  (accept),
    .cnt_o  (cyc_cnt),
    .shift_o(shift_k)
  );

  srt_step #(.PW(PW), .KW(KW)) u_step (
    .p_i    (prob_q),
    .bit_i  (bit_i),
    .shift_i(shift_k),
    .p_o    (step_p)
  );

  always_comb begin
    prob_d = prob_q;
    if (load_i)      prob_d = prior_i;
    else if (accept) prob_d = step_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prob_q <= RESET_PROB;
    else if (prob_en) prob_q <= prob_d;
  end

  assign prob_o = prob_q;

endmodule

// File: rtl/stream_prob_tracker_chk.sv
module stream_prob_tracker_chk #(
  parameter int PW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic [PW-1:0] prior_i,
  input logic          valid_i,
  input logic          bit_i,
  input logic [PW-1:0] prob_o,
  input logic [CW-1:0] cyc_cnt
);

  a_r2_load_presets: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> prob_o == $past(prior_i));

  a_r2_load_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cyc_cnt == '0);

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !valid_i) |=> $stable(prob_o) && $stable(cyc_cnt));

  a_r9_one_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !load_i && bit_i) |=> prob_o >= $past(prob_o));

  a_r9_zero_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !load_i && !bit_i) |=> prob_o <= $past(prob_o));

  a_r10_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !load_i && (&cyc_cnt)) |=> (&cyc_cnt));

endmodule

bind stream_prob_tracker stream_prob_tracker_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load_i (load_i),
  .prior_i(prior_i),
  .valid_i(valid_i),
  .bit_i  (bit_i),
  .prob_o (prob_o),
  .cyc_cnt(cyc_cnt)
);

// File: tb/stream_prob_tracker_test.sv
`timescale 1ns/1ps
module stream_prob_tracker_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i, valid_i, bit_i;
  logic [15:0] prior_i;
  logic [15:0] prob_o;

  int n_chk  = 0;
  int n_fail = 0;
  int m_p;
  int m_cnt;

  always #4 clk = ~clk;

  stream_prob_tracker uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .prior_i(prior_i),
    .valid_i(valid_i), .bit_i(bit_i), .prob_o(prob_o)
  );

  function automatic int k_for(input int cyc);
    if (cyc <= 33)       return 2;
    else if (cyc <= 110) return 3;
    else                 return 4;
  endfunction

  function automatic int model_step(input int p, input bit b, input int k);
    int r;
    if (b) r = p + ((65536 - p) >> k);
    else   r = p - ((p + (1 << k) - 1) >> k);
    if (r < 0) r = 0;
    if (r > 65535) r = 65535;
    return r;
  endfunction

  task automatic check(input string req, input int exp_v);
    n_chk++;
    if (int'(prob_o) != exp_v) begin
      n_fail++;
      $display("FAIL %s: prob_o actual 0x%04h expected 0x%04h (cycle %0d)",
               req, prob_o, exp_v[15:0], m_cnt);
    end
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic cyc(input bit ld, input int pr, input bit v, input bit b,
                     input string req);
    load_i = ld; prior_i = pr[15:0]; valid_i = v; bit_i = b;
    if (ld) begin
      m_p = pr; m_cnt = 0;
    end else if (v) begin
      m_p = model_step(m_p, b, k_for(m_cnt));
      if (m_cnt < 255) m_cnt++;
    end
    @(negedge clk);
    check(req, m_p);
  endtask

  task automatic t_reset;
    check("R1", 32768);
    cyc(1'b0, 0, 1'b1, 1'b1, "R1");  // 0x8000 + 0x2000
  endtask

  task automatic t_load;
    cyc(1'b1, 16'h1234, 1'b1, 1'b1, "R3");
    cyc(1'b1, 16'h0100, 1'b0, 1'b0, "R2");
    cyc(1'b0, 0, 1'b1, 1'b0, "R2");
  endtask

  task automatic t_hold;
    for (int i = 0; i < 4; i++) cyc(1'b0, 16'hFFFF, 1'b0, i[0], "R4");
  endtask

  task automatic t_schedule;
    string tag;
    cyc(1'b1, 16'h8000, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 130; i++) begin
      tag = (m_cnt <= 33) ? "R6" : (m_cnt <= 110) ? "R7" : "R8";
      cyc(1'b0, 0, 1'b1, (i % 3) != 0, tag);
      if (i % 7 == 0) cyc(1'b0, 0, 1'b0, 1'b1, "R5");
    end
  endtask

  task automatic t_saturate;
    cyc(1'b1, 16'hFFF0, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 40; i++) cyc(1'b0, 0, 1'b1, 1'b1, "R9");
    cyc(1'b1, 16'h0009, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 40; i++) cyc(1'b0, 0, 1'b1, 1'b0, "R9");
    check("R9", 0);
  endtask

  task automatic t_count_sat;
    cyc(1'b1, 16'h4000, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 300; i++)
      cyc(1'b0, 0, 1'b1, (i % 2) == 0, (m_cnt >= 255) ? "R10" : "R8");
  endtask

  task automatic t_restart;
    for (int i = 0; i < 3; i++) cyc(1'b0, 0, 1'b1, 1'b1, "R10");
    cyc(1'b1, 16'h4000, 1'b1, 1'b0, "R11");
    for (int i = 0; i < 4; i++) cyc(1'b0, 0, 1'b1, i[0], "R11");
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; valid_i = 1'b0; bit_i = 1'b0; prior_i = '0;
    m_p = 32768; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_hold();
    t_schedule();
    t_saturate();
    t_count_sat();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule